// File: doc/BRIEF.md
# Protection Entry Permission Checker

This block decides whether a single memory access may proceed, given the protection entry that an upstream address matcher has already selected. It looks at the entry's lock, read, write and execute flags, the kind of access, whether the hart runs in machine mode, whether any entry matched at all, and two security-policy bits: a lockdown bit and a default-deny bit. It returns a permit signal and, on denial, a fault code chosen by the access kind.

With lockdown clear, the usual rules hold: machine mode passes through unlocked entries, and locked entries or lower privileges are held to the flag bits. With lockdown set, an entry only applies to the privilege its lock bit names. Three flag patterns that are otherwise reserved become shared regions: shared code, shared data, and a read-only region for all privileges. Accesses that match no entry are denied below machine mode. In machine mode they follow the policy bits. The block is purely combinational and sits in the address-check path of a load/store or fetch unit. A build parameter removes the lockdown feature, and the policy inputs are then ignored.

Top module: `pmp_perm_check`

## Requirements
- R1: With lockdown off, a matched entry whose lock bit (cfg bit 7) is 0 permits every access in machine mode.
- R2: With lockdown off, a matched entry is held to its flags (read = cfg bit 0, write = bit 1, execute = bit 2) when its lock bit is 1 in machine mode, and always below machine mode.
- R3: With lockdown on and an entry with lock 1, read 0, write 1: execute is permitted at every privilege, read only in machine mode with execute flag 1, and write never.
- R4: With lockdown on and an entry with lock 0, read 0, write 1: read is always permitted, write is permitted in machine mode or when the execute flag is 1, and execute never.
- R5: With lockdown on and lock, read, write and execute all 1: read is permitted and write and execute are denied at every privilege.
- R6: With lockdown on, any other flag pattern grants its own flags only when machine mode equals the lock bit; otherwise the access is denied.
- R7: With no matching entry below machine mode, every access is denied.
- R8: With no matching entry in machine mode: default-deny set denies all; else lockdown set denies execute only; else all are permitted.
- R9: fault_o is 00 when permitted; on denial it is 01 for a read, 10 for a write and 11 for an execute.
- R10: With LOCKDOWN_EN = 0 the lockdown and default-deny inputs have no effect on either output.
- R11: Access code 11 (reserved) behaves exactly like a read (code 00); write is 01 and execute is 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | 8 | Selected entry config: bit 0 read, bit 1 write, bit 2 execute, bit 7 lock |
| acc_i | input | 2 | Access kind: 00 read, 01 write, 10 execute, 11 treated as read |
| mach_i | input | 1 | High when the effective privilege is machine mode |
| hit_i | input | 1 | High when some entry matched the address |
| mml_i | input | 1 | Lockdown policy bit |
| mmwp_i | input | 1 | Default-deny policy bit for unmatched machine accesses |
| allow_o | output | 1 | Access permitted |
| fault_o | output | 2 | Fault code, 00 when permitted |

## Verification
The in-line assertions watch, whenever the inputs change, the shared-code execute grant, the read-only region's outcome, the denial of unmatched user accesses, the default-deny rule, the unlocked machine pass-through and the agreement between permit and fault code. The full permission table under each mode, the fault code per access kind, the reserved access code and the build without lockdown can only be shown by the bench. It sweeps every flag pattern, privilege and access kind against a model written from the requirements.

// File: rtl/pmp_perm_pkg.sv
package pmp_perm_pkg;

  localparam int CFG_BITS  = 8;
  localparam int POS_R     = 0;
  localparam int POS_W     = 1;
  localparam int POS_X     = 2;
  localparam int POS_L     = 7;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_EXEC  = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_LOAD  = 2'b01,
    FLT_STORE = 2'b10,
    FLT_FETCH = 2'b11
  } flt_e;

  typedef struct packed {
    logic l;
    logic r;
    logic w;
    logic x;
  } perm_t;

  function automatic logic flag_ok(perm_t p, acc_e a);
    case (a)
      ACC_WRITE: flag_ok = p.w;
      ACC_EXEC:  flag_ok = p.x;
      default:   flag_ok = p.r;
    endcase
  endfunction

endpackage

// File: rtl/pmp_rule_legacy.sv
module pmp_rule_legacy
  import pmp_perm_pkg::*;
(
  input  perm_t perm_i,
  input  acc_e  acc_i,
  input  logic  mach_i,
  output logic  allow_o
);

  always_comb begin
    if (mach_i && !perm_i.l) begin
      allow_o = 1'b1;
    end else begin
      allow_o = flag_ok(perm_i, acc_i);
    end
  end

endmodule

// File: rtl/pmp_rule_lockdown.sv
module pmp_rule_lockdown
  import pmp_perm_pkg::*;
(
  input  perm_t perm_i,
  input  acc_e  acc_i,
  input  logic  mach_i,
  output logic  allow_o
);

  logic shr_code;
  logic shr_data;
  logic shr_ro;

  assign shr_code = perm_i.l && !perm_i.r && perm_i.w;
  assign shr_data = !perm_i.l && !perm_i.r && perm_i.w;
  assign shr_ro   = perm_i.l && perm_i.r && perm_i.w && perm_i.x;

  always_comb begin
    allow_o = 1'b0;
    if (shr_code) begin
      case (acc_i)
        ACC_EXEC:  allow_o = 1'b1;
        ACC_WRITE: allow_o = 1'b0;
        default:   allow_o = mach_i && perm_i.x;
      endcase
    end else if (shr_data) begin
      case (acc_i)
        ACC_EXEC:  allow_o = 1'b0;
        ACC_WRITE: allow_o = mach_i || perm_i.x;
        default:   allow_o = 1'b1;
      endcase
    end else if (shr_ro) begin
      allow_o = (acc_i == ACC_READ) || (acc_i == ACC_RSVD);
    end else if (mach_i == perm_i.l) begin
      allow_o = flag_ok(perm_i, acc_i);
    end
  end

endmodule

// File: rtl/pmp_rule_nomatch.sv
module pmp_rule_nomatch
  import pmp_perm_pkg::*;
(
  input  acc_e  acc_i,
  input  logic  mach_i,
  input  logic  mml_i,
  input  logic  mmwp_i,
  output logic  allow_o
);

  always_comb begin
    if (!mach_i || mmwp_i) begin
      allow_o = 1'b0;
    end else if (mml_i) begin
      allow_o = (acc_i != ACC_EXEC);
    end else begin
      allow_o = 1'b1;
    end
  end

endmodule

// File: rtl/pmp_perm_check.sv
module pmp_perm_check
  import pmp_perm_pkg::*;
#(
  parameter bit LOCKDOWN_EN = 1'b1
) (
  input  logic [CFG_BITS-1:0] cfg_i,
  input  logic [1:0]          acc_i,
  input  logic                mach_i,
  input  logic                hit_i,
  input  logic                mml_i,
  input  logic                mmwp_i,
  output logic                allow_o,
  output logic [1:0]          fault_o
);

  perm_t perm;
  acc_e  acc;
  logic  mml_eff;
  logic  mmwp_eff;
  logic  ok_legacy;
  logic  ok_lock;
  logic  ok_miss;
  logic  unused_cfg;

  assign perm.l = cfg_i[POS_L];
  assign perm.r = cfg_i[POS_R];
  assign perm.w = cfg_i[POS_W];
  assign perm.x = cfg_i[POS_X];
  assign unused_cfg = ^cfg_i[POS_L-1:POS_X+1];

  // reserved code folds onto read
  assign acc = (acc_i == ACC_RSVD) ? ACC_READ : acc_e'(acc_i);

  generate
    if (LOCKDOWN_EN) begin : g_pol
      assign mml_eff  = mml_i;
      assign mmwp_eff = mmwp_i;
    end else begin : g_nopol
      logic unused_pol;
      assign unused_pol = mml_i ^ mmwp_i;
      assign mml_eff  = 1'b0;
      assign mmwp_eff = 1'b0;
    end
  endgenerate

  pmp_rule_legacy u_legacy (
    .perm_i (perm),
    .acc_i  (acc),
    .mach_i (mach_i),
    .allow_o(ok_legacy)
  );

  pmp_rule_lockdown u_lock (
    .perm_i (perm),
    .acc_i  (acc),
    .mach_i (mach_i),
    .allow_o(ok_lock)
  );

  pmp_rule_nomatch u_miss (
    .acc_i  (acc),
    .mach_i (mach_i),
    .mml_i  (mml_eff),
    .mmwp_i (mmwp_eff),
    .allow_o(ok_miss)
  );

  always_comb begin
    if (!hit_i) begin
      allow_o = ok_miss;
    end else if (mml_eff) begin
      allow_o = ok_lock;
    end else begin
      allow_o = ok_legacy;
    end
  end

  always_comb begin
    if (allow_o) begin
      fault_o = FLT_NONE;
    end else begin
      case (acc)
        ACC_WRITE: fault_o = FLT_STORE;
        ACC_EXEC:  fault_o = FLT_FETCH;
        default:   fault_o = FLT_LOAD;
      endcase
    end
  end

  // in-line checks on submodule results
  always_comb begin
    a_r7_user_miss_denied: assert (hit_i || mach_i || !ok_miss);
    a_r8_default_deny: assert (!(mmwp_eff && !hit_i) || !allow_o);
    a_r1_unlocked_machine: assert (!(hit_i && !mml_eff && mach_i && !perm.l) || allow_o);
    a_r3_shared_exec: assert (!(perm.l && !perm.r && perm.w && acc == ACC_EXEC) || ok_lock);
    a_r5_readonly: assert (!(perm.l && perm.r && perm.w && perm.x) || (ok_lock == (acc == ACC_READ)));
    a_r9_code_matches: assert ((fault_o == FLT_NONE) == allow_o);
  end

endmodule

// File: tb/pmp_perm_check_tb.sv
module pmp_perm_check_tb;

  logic       clk;
  logic       rst_n;
  logic [7:0] cfg;
  logic [1:0] acc;
  logic       mach, hit, mml, mmwp;
  logic       allow, allow_off;
  logic [1:0] fault, fault_off;
  int         checks = 0;
  int         errors = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pmp_perm_check #(.LOCKDOWN_EN(1'b1)) u_dut (
    .cfg_i(cfg), .acc_i(acc), .mach_i(mach), .hit_i(hit),
    .mml_i(mml), .mmwp_i(mmwp), .allow_o(allow), .fault_o(fault));

  pmp_perm_check #(.LOCKDOWN_EN(1'b0)) u_dut_off (
    .cfg_i(cfg), .acc_i(acc), .mach_i(mach), .hit_i(hit),
    .mml_i(mml), .mmwp_i(mmwp), .allow_o(allow_off), .fault_o(fault_off));

  // reference: a 0 read, 1 write, 2 exec
  function automatic bit m_flag(bit r, bit w, bit x, int a);
    return (a == 1) ? w : (a == 2) ? x : r;
  endfunction

  function automatic bit m_allow(bit l, bit r, bit w, bit x, int a,
                                 bit m, bit h, bit ld, bit dd);
    if (!h) begin
      if (!m || dd) return 1'b0;
      if (ld) return a != 2;
      return 1'b1;
    end
    if (!ld) return (m && !l) ? 1'b1 : m_flag(r, w, x, a);
    if (l && !r && w) return (a == 2) ? 1'b1 : (a == 0) ? (m && x) : 1'b0;
    if (!l && !r && w) return (a == 0) ? 1'b1 : (a == 1) ? (m || x) : 1'b0;
    if (l && r && w && x) return a == 0;
    if (m == l) return m_flag(r, w, x, a);
    return 1'b0;
  endfunction

  function automatic logic [1:0] m_fault(bit ok, int a);
    if (ok) return 2'b00;
    return (a == 1) ? 2'b10 : (a == 2) ? 2'b11 : 2'b01;
  endfunction

  task automatic apply(int c, int a, bit m, bit h, bit ld, bit dd);
    @(negedge clk);
    cfg  = {c[3], 4'b0000, c[2], c[1], c[0]};
    acc  = a[1:0];
    mach = m; hit = h; mml = ld; mmwp = dd;
    #1;
  endtask

  task automatic check(string tag, logic a_act, logic [1:0] f_act,
                       logic a_exp, logic [1:0] f_exp);
    checks++;
    if (a_act !== a_exp || f_act !== f_exp) begin
      errors++;
      $display("FAIL %s cfg=%h acc=%0d mach=%0b hit=%0b mml=%0b mmwp=%0b: allow=%0b fault=%0d expected allow=%0b fault=%0d",
               tag, cfg, acc, mach, hit, mml, mmwp, a_act, f_act, a_exp, f_exp);
    end
  endtask

  // sweep all matched entries for given mode and ref privilege filter
  task automatic sweep(string tag, bit ld, int want_l, int want_r, int want_w, int want_x);
    for (int c = 0; c < 16; c++) begin
      if ((want_l < 0 || c[3] == want_l[0]) && (want_r < 0 || c[0] == want_r[0]) &&
          (want_w < 0 || c[1] == want_w[0]) && (want_x < 0 || c[2] == want_x[0])) begin
        for (int a = 0; a < 3; a++) begin
          for (int m = 0; m < 2; m++) begin
            bit e;
            apply(c, a, m[0], 1'b1, ld, 1'b0);
            e = m_allow(c[3], c[0], c[1], c[2], a, m[0], 1'b1, ld, 1'b0);
            check(tag, allow, fault, e, m_fault(e, a));
          end
        end
      end
    end
  endtask

  task automatic t_reset();
    apply(0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R7 reset-state", allow, fault, 1'b0, 2'b01);
  endtask

  task automatic t_legacy();
    sweep("R1", 1'b0, 0, -1, -1, -1);
    sweep("R2", 1'b0, 1, -1, -1, -1);
  endtask

  task automatic t_exec_shared();
    sweep("R3", 1'b1, 1, 0, 1, -1);
  endtask

  task automatic t_data_shared();
    sweep("R4", 1'b1, 0, 0, 1, -1);
  endtask

  task automatic t_readonly();
    sweep("R5", 1'b1, 1, 1, 1, 1);
  endtask

  task automatic t_lock_match();
    sweep("R6", 1'b1, -1, 1, -1, -1);
    sweep("R6", 1'b1, -1, 0, 0, -1);
  endtask

  task automatic t_miss();
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 3; a++) begin
        apply(5, a, 1'b0, 1'b0, k[0], k[1]);
        check("R7", allow, fault, 1'b0, m_fault(1'b0, a));
      end
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 3; a++) begin
        bit e;
        apply(0, a, 1'b1, 1'b0, k[0], k[1]);
        e = m_allow(0, 0, 0, 0, a, 1'b1, 1'b0, k[0], k[1]);
        check("R8", allow, fault, e, m_fault(e, a));
      end
  endtask

  task automatic t_codes();
    apply(8, 0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 read", allow, fault, 1'b0, 2'b01);
    apply(8, 1, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 write", allow, fault, 1'b0, 2'b10);
    apply(8, 2, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R9 exec", allow, fault, 1'b0, 2'b11);
    apply(15, 2, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R9 permit", allow, fault, 1'b1, 2'b00);
    for (int c = 0; c < 16; c++)
      for (int k = 0; k < 2; k++) begin
        bit e;
        apply(c, 3, k[0], 1'b1, 1'b1, 1'b0);
        e = m_allow(c[3], c[0], c[1], c[2], 0, k[0], 1'b1, 1'b1, 1'b0);
        check("R11", allow, fault, e, m_fault(e, 0));
      end
  endtask

  task automatic t_disabled();
    for (int c = 0; c < 16; c++)
      for (int a = 0; a < 3; a++)
        for (int k = 0; k < 4; k++) begin
          bit e;
          apply(c, a, k[0], k[1], 1'b1, 1'b1);
          e = m_allow(c[3], c[0], c[1], c[2], a, k[0], k[1], 1'b0, 1'b0);
          check("R10", allow_off, fault_off, e, m_fault(e, a));
        end
  endtask

  initial begin
    rst_n = 1'b0;
    cfg = '0; acc = '0; mach = 1'b0; hit = 1'b0; mml = 1'b0; mmwp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_legacy();
    t_exec_shared();
    t_data_shared();
    t_readonly();
    t_lock_match();
    t_miss();
    t_codes();
    t_disabled();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule